// File: doc/BRIEF.md
# DMA Burst Length Planner

This block turns one DMA transfer, given as a beat count, into a series of host-bus burst descriptors. Each descriptor gives an AHB-style burst type and the number of beats in that burst. A consumer takes the descriptors one at a time through a valid/ready handshake. Address generation, data movement and bus signalling are handled elsewhere.

The configuration is sampled when a transfer starts. It consists of a main burst length, a receive-only burst length with a bit that enables it, a direction flag and a fixed-burst mode bit. The effective length is capped at half the FIFO depth. An illegal length value raises an error flag, and the transfer then proceeds in single-beat bursts. In fixed mode only the fixed-size burst types and SINGLE are used. In the other mode, each burst is one undefined-length INCR covering as much as the length allows.

Top module: `burst_planner`

## Requirements
- R1: After a synchronous reset, `burst_valid` and `cfg_err` are 0.
- R2: `xfer_start` is accepted only while no descriptor is valid and `xfer_beats` is nonzero. The first descriptor is valid in the following cycle. A start while busy, or with zero beats, has no effect.
- R3: The length in use is `cfg_rx_len` when both `cfg_split` and `xfer_rx` are 1. Otherwise it is `cfg_len`.
- R4: Legal lengths are 1, 2, 4, 8, 16 and 32. Any other value sets `cfg_err` to 1 and makes every burst of that transfer a 1-beat SINGLE. `cfg_err` holds its value until the next accepted start.
- R5: The effective length is the smaller of the selected length and FIFO_DEPTH/2.
- R6: With `cfg_fixed` = 1, each burst uses the largest of 16, 8 and 4 that fits both the effective length and the remaining beats. The kind codes are INCR16=7, INCR8=5 and INCR4=3. If none of these fits, the burst is a 1-beat SINGLE (code 0). A length of 32 therefore yields INCR16 bursts.
- R7: With `cfg_fixed` = 0, each burst is n = min(effective length, remaining) beats. It uses kind INCR (code 1) when n > 1 and SINGLE (code 0) when n = 1.
- R8: While `burst_valid` = 1 and `burst_ready` = 0, the kind and beat outputs stay unchanged. Each accepted burst lowers the remaining count by its beats. When the count reaches zero, `burst_valid` drops in the next cycle.
- R9: Changes to `cfg_len`, `cfg_rx_len`, `cfg_split`, `cfg_fixed` and `xfer_rx` after a transfer has been accepted do not affect that transfer's descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Request to begin a new transfer |
| xfer_beats | input | CNT_W | Total beats of the transfer |
| xfer_rx | input | 1 | 1 for receive direction, 0 for transmit |
| cfg_len | input | 6 | Main burst length |
| cfg_rx_len | input | 6 | Receive-only burst length |
| cfg_split | input | 1 | Enables the receive-only length |
| cfg_fixed | input | 1 | Fixed-size burst mode |
| burst_valid | output | 1 | Descriptor is valid |
| burst_ready | input | 1 | Consumer takes the descriptor |
| burst_kind | output | 3 | Burst type code |
| burst_beats | output | 6 | Beats in this burst |
| cfg_err | output | 1 | Selected length was illegal |

## Verification
The bench drives directed transfers in both modes:
- Remainders that are not multiples of the length, which tell the INCR tail apart from a truncated fixed burst.
- Remainders below four, which show the fall-back to SINGLE.
- A programmed 32, which separates the FIFO cap from the fixed-mode INCR16 limit.

The split bit is exercised with all direction combinations, and an illegal length is followed by a legal one. A randomized sweep mixes stalling ready patterns, configuration changes mid-transfer, and starts issued while busy. A behavioural model is compared against the outputs on every cycle.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned LEN_W = 6;

  typedef enum logic [2:0] {
    BK_SINGLE = 3'd0,
    BK_INCR   = 3'd1,
    BK_INCR4  = 3'd3,
    BK_INCR8  = 3'd5,
    BK_INCR16 = 3'd7
  } burst_kind_e;
endpackage

// File: rtl/bl_len_pick.sv
module bl_len_pick
  import bl_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64
) (
  input  logic [LEN_W-1:0] main_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             split,
  input  logic             is_rx,
  output logic [LEN_W-1:0] eff_len,
  output logic             bad
);
  localparam int unsigned HALF   = FIFO_DEPTH / 2;
  localparam int unsigned HALF_C = (HALF > 32) ? 32 : ((HALF < 1) ? 1 : HALF);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(HALF_C);

  logic [LEN_W-1:0] sel;

  always_comb begin
    sel = (split && is_rx) ? rx_len : main_len;
    bad = ($countones(sel) != 1);
    if (bad)
      eff_len = LEN_W'(1);
    else if (sel > CAP)
      eff_len = CAP;
    else
      eff_len = sel;
  end
endmodule

// File: rtl/bl_shape.sv
module bl_shape
  import bl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] rem,
  input  logic [LEN_W-1:0] len,
  input  logic             fixed,
  output burst_kind_e      kind,
  output logic [LEN_W-1:0] beats
);
  localparam int unsigned TIERS = 3;

  logic [TIERS-1:0] fit;

  genvar t;
  generate
    for (t = 0; t < TIERS; t++) begin : g_tier
      localparam int unsigned SZ = 16 >> t;
      assign fit[t] = (len >= LEN_W'(SZ)) && (rem >= CNT_W'(SZ));
    end
  endgenerate

  logic [CNT_W-1:0] len_w;
  logic [LEN_W-1:0] n_incr;

  always_comb begin
    len_w  = CNT_W'(len);
    n_incr = (rem < len_w) ? rem[LEN_W-1:0] : len;
    if (fixed) begin
      if (fit[0]) begin
        kind = BK_INCR16; beats = LEN_W'(16);
      end else if (fit[1]) begin
        kind = BK_INCR8;  beats = LEN_W'(8);
      end else if (fit[2]) begin
        kind = BK_INCR4;  beats = LEN_W'(4);
      end else begin
        kind = BK_SINGLE; beats = LEN_W'(1);
      end
    end else begin
      beats = n_incr;
      kind  = (n_incr == LEN_W'(1)) ? BK_SINGLE : BK_INCR;
    end
  end
endmodule

// File: rtl/burst_planner.sv
module burst_planner
  import bl_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FIFO_DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_start,
  input  logic [CNT_W-1:0] xfer_beats,
  input  logic             xfer_rx,
  input  logic [5:0]       cfg_len,
  input  logic [5:0]       cfg_rx_len,
  input  logic             cfg_split,
  input  logic             cfg_fixed,
  output logic             burst_valid,
  input  logic             burst_ready,
  output logic [2:0]       burst_kind,
  output logic [5:0]       burst_beats,
  output logic             cfg_err
);
  localparam int unsigned HALF_LIM = (FIFO_DEPTH / 2 > 32) ? 32 : FIFO_DEPTH / 2;

  logic [CNT_W-1:0] rem_q;
  logic [LEN_W-1:0] len_q;
  logic             fixed_q;
  logic             err_q;
  logic             vld_q;
  burst_kind_e      kind_q;
  logic [LEN_W-1:0] beats_q;

  logic [LEN_W-1:0] pick_len;
  logic             pick_bad;
  logic             load, take;
  logic [CNT_W-1:0] rem_after;
  logic [CNT_W-1:0] sh_rem;
  logic [LEN_W-1:0] sh_len;
  logic             sh_fixed;
  burst_kind_e      sh_kind;
  logic [LEN_W-1:0] sh_beats;

  bl_len_pick #(.FIFO_DEPTH(FIFO_DEPTH)) u_pick (
    .main_len (cfg_len),
    .rx_len   (cfg_rx_len),
    .split    (cfg_split),
    .is_rx    (xfer_rx),
    .eff_len  (pick_len),
    .bad      (pick_bad)
  );

  always_comb begin
    load      = xfer_start && !vld_q && (xfer_beats != '0);
    take      = vld_q && burst_ready;
    rem_after = rem_q - CNT_W'(beats_q);
    sh_rem    = load ? xfer_beats : rem_after;
    sh_len    = load ? pick_len   : len_q;
    sh_fixed  = load ? cfg_fixed  : fixed_q;
  end

  bl_shape #(.CNT_W(CNT_W)) u_shape (
    .rem   (sh_rem),
    .len   (sh_len),
    .fixed (sh_fixed),
    .kind  (sh_kind),
    .beats (sh_beats)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      len_q   <= '0;
      fixed_q <= 1'b0;
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
      kind_q  <= BK_SINGLE;
      beats_q <= '0;
    end else if (load) begin
      rem_q   <= xfer_beats;
      len_q   <= pick_len;
      fixed_q <= cfg_fixed;
      err_q   <= pick_bad;
      vld_q   <= 1'b1;
      kind_q  <= sh_kind;
      beats_q <= sh_beats;
    end else if (take) begin
      rem_q <= rem_after;
      if (rem_after == '0) begin
        vld_q <= 1'b0;
      end else begin
        kind_q  <= sh_kind;
        beats_q <= sh_beats;
      end
    end
  end

  assign burst_valid = vld_q;
  assign burst_kind  = kind_q;
  assign burst_beats = beats_q;
  assign cfg_err     = err_q;

  // Stall keeps the descriptor unchanged
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_kind) && $stable(burst_beats)));

  // A burst never exceeds the beats still owed
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (CNT_W'(burst_beats) <= rem_q) && (burst_beats != '0));

  // Burst size respects the FIFO cap
  assert_fifo_cap_R5: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (int'(burst_beats) <= HALF_LIM));

  // Fixed mode never emits undefined-length INCR
  assert_fixed_kinds_R6: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && fixed_q) |-> (burst_kind != 3'd1));

  // INCR mode emits only SINGLE or INCR, SINGLE exactly for one beat
  assert_incr_kinds_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && !fixed_q) |-> ((burst_kind == 3'd0 && burst_beats == 6'd1) ||
                                   (burst_kind == 3'd1 && burst_beats > 6'd1)));

  // Illegal length forces single beats
  assert_err_single_R4: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && cfg_err) |-> (burst_kind == 3'd0 && burst_beats == 6'd1));

  // Accepted start shows a descriptor next cycle
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && !burst_valid && xfer_beats != '0) |=> burst_valid);

  // Last accept ends the transfer
  assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && burst_ready && CNT_W'(burst_beats) == rem_q) |=> !burst_valid);
endmodule

// File: tb/sim_burst_planner.sv
module sim_burst_planner;
  localparam int CNT_W = 16;
  localparam int FIFO_DEPTH = 32;
  localparam int HALF = FIFO_DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_start = 1'b0;
  logic [CNT_W-1:0] xfer_beats = '0;
  logic xfer_rx = 1'b0;
  logic [5:0] cfg_len = 6'd1;
  logic [5:0] cfg_rx_len = 6'd1;
  logic cfg_split = 1'b0;
  logic cfg_fixed = 1'b0;
  logic burst_valid;
  logic burst_ready = 1'b1;
  logic [2:0] burst_kind;
  logic [5:0] burst_beats;
  logic cfg_err;

  always #2.5 clk = ~clk;

  burst_planner #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u0 (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_beats(xfer_beats),
    .xfer_rx(xfer_rx), .cfg_len(cfg_len), .cfg_rx_len(cfg_rx_len),
    .cfg_split(cfg_split), .cfg_fixed(cfg_fixed), .burst_valid(burst_valid),
    .burst_ready(burst_ready), .burst_kind(burst_kind),
    .burst_beats(burst_beats), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";
  bit rnd_ready = 1'b0;

  int m_vld = 0, m_rem = 0, m_len = 0, m_fx = 0, m_err = 0, m_kind = 0, m_beats = 0;

  function automatic void shape(input int rem, input int len, input int fx,
                                output int k, output int b);
    if (fx != 0) begin
      b = 1; k = 0;
      for (int s = 16; s >= 4; s = s / 2)
        if (b == 1 && s <= len && s <= rem) begin
          b = s;
          k = (s == 16) ? 7 : ((s == 8) ? 5 : 3);
        end
    end else begin
      b = (rem < len) ? rem : len;
      k = (b == 1) ? 0 : 1;
    end
  endfunction

  function automatic void pick(output int len, output int err);
    int sel;
    bit ok;
    sel = (cfg_split && xfer_rx) ? int'(cfg_rx_len) : int'(cfg_len);
    ok = 0;
    for (int v = 1; v <= 32; v = v * 2) if (sel == v) ok = 1;
    if (!ok) begin len = 1; err = 1; end
    else begin len = (sel > HALF) ? HALF : sel; err = 0; end
  endfunction

  // reference model
  always @(posedge clk) begin
    if (rst) begin
      m_vld = 0; m_rem = 0; m_err = 0; m_kind = 0; m_beats = 0;
    end else if (xfer_start && m_vld == 0 && xfer_beats != 0) begin
      pick(m_len, m_err);
      m_fx = int'(cfg_fixed);
      m_rem = int'(xfer_beats);
      shape(m_rem, m_len, m_fx, m_kind, m_beats);
      m_vld = 1;
    end else if (m_vld != 0 && burst_ready) begin
      m_rem = m_rem - m_beats;
      if (m_rem == 0) m_vld = 0;
      else shape(m_rem, m_len, m_fx, m_kind, m_beats);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(tag, "valid", int'(burst_valid), m_vld);
      check(tag, "err", int'(cfg_err), m_err);
      if (m_vld != 0) begin
        check(tag, "kind", int'(burst_kind), m_kind);
        check(tag, "beats", int'(burst_beats), m_beats);
      end
    end
    if (rnd_ready) burst_ready <= ($urandom % 3) != 0;
    else burst_ready <= 1'b1;
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
    finish_up();
  end

  task automatic run(input int beats, input int len, input int rxlen,
                     input bit split, input bit rx, input bit fx);
    @(negedge clk);
    cfg_len = 6'(len); cfg_rx_len = 6'(rxlen); cfg_split = split;
    xfer_rx = rx; cfg_fixed = fx; xfer_beats = CNT_W'(beats);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    while (m_vld != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    check("R1", "reset valid", int'(burst_valid), 0);
    check("R1", "reset err", int'(cfg_err), 0);

    tag = "R7"; run(21, 8, 1, 0, 0, 0);
    tag = "R7"; run(1, 16, 1, 0, 0, 0);
    tag = "R6"; run(31, 16, 1, 0, 0, 1);
    tag = "R6"; run(3, 8, 1, 0, 0, 1);
    tag = "R6"; run(10, 2, 1, 0, 0, 1);
    tag = "R5"; run(40, 32, 1, 0, 0, 0);
    tag = "R5"; run(40, 32, 1, 0, 0, 1);
    tag = "R3"; run(20, 4, 16, 1, 1, 0);
    tag = "R3"; run(20, 4, 16, 1, 0, 0);
    tag = "R3"; run(20, 4, 16, 0, 1, 0);
    tag = "R4"; run(3, 6, 1, 0, 0, 0);
    tag = "R4"; run(3, 8, 0, 1, 1, 1);
    tag = "R4"; run(9, 8, 1, 0, 0, 0);

    // R2: zero beats ignored
    tag = "R2";
    @(negedge clk);
    xfer_beats = '0; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    check("R2", "zero-beat start valid", int'(burst_valid), 0);

    // R8 / R9 / R2: stalls, config changes and starts while busy
    rnd_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int lens[6] = '{1, 2, 4, 8, 16, 32};
      int l, rl;
      l  = ($urandom % 8 == 0) ? int'($urandom % 64) : lens[$urandom % 6];
      rl = lens[$urandom % 6];
      tag = (i % 2 == 0) ? "R8" : "R9";
      @(negedge clk);
      cfg_len = 6'(l); cfg_rx_len = 6'(rl); cfg_split = $urandom % 2;
      xfer_rx = $urandom % 2; cfg_fixed = $urandom % 2;
      xfer_beats = CNT_W'(1 + $urandom % 70);
      xfer_start = 1'b1;
      @(negedge clk);
      while (m_vld != 0) begin
        xfer_start = $urandom % 2;
        xfer_beats = CNT_W'(1 + $urandom % 70);
        cfg_len = 6'($urandom % 64); cfg_rx_len = 6'($urandom % 64);
        cfg_fixed = $urandom % 2; cfg_split = $urandom % 2; xfer_rx = $urandom % 2;
        @(negedge clk);
        if (m_vld == 0) xfer_start = 1'b0;
      end
      xfer_start = 1'b0;
      @(negedge clk);
    end
    rnd_ready = 1'b0;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule